// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a single-bus datapath, built as a microcode engine. A micro-program counter addresses an internal control store. Each stored word carries three things: the control lines for the current step, a two-bit branch-control code, and a branch address. In every cycle the sequencer drives the decoded control lines and picks the next micro-address. It picks from four sources: the incremented micro-PC, a start address looked up from the macro-opcode, the branch address in the word, or a fixed exception vector. Some of the codes test one bit of a condition input. That bit can carry condition codes, datapath status or an external signal.

The store opens with one instruction-fetch routine that every instruction shares. That routine ends in a dispatch through the opcode map. The routines for each opcode follow it: two ALU operations, a store, a conditional branch, a jump, a test on a selectable bit, and a no-op. Control signals that can never be active together are kept as binary codes in the store, with code 0 meaning none, and are expanded by decoders at the output. These groups are the bus drivers, the ALU function selects and the memory commands. A step that waits for memory stalls the micro-PC until memory reports completion. A step marked as the end of an instruction returns to fetch, or goes to the exception handler when an exception has been requested.

Top module: `useq_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, `upc_o` becomes 0. This overrides a memory wait, an end step and a pending exception, and the pending exception is discarded.
- R2: The fetch routine sits at addresses 0, 1 and 2. Address 0 asserts pc_out, mem_rd, ma_in, inc4 and c_in. Address 1 asserts c_out, pc_in and wait. Address 2 asserts md_out and ir_in, then dispatches.
- R3: The branch-control code sets the next address when there is no wait stall and no end step. Code 0 gives micro-PC+1, modulo the store size. Code 1 jumps to the branch address. Code 2 jumps if the selected condition bit is 1 and otherwise gives micro-PC+1. Code 3 gives the opcode map address.
- R4: The opcode map sends 0 to 3, 1 to 4, 2 to 7, 3 to 10, 4 to 13, 5 to 16 and 7 to 17. Opcode 6 and every opcode of 8 or more go to 3, a bare end step.
- R5: Address 13 tests `cond_in[0]` and goes to 15 if it is 1, else to 14. Address 17 tests `cond_in[3]` and goes to 19 if it is 1, else to 18. No other condition bit has any effect on either.
- R6: A step that asserts end, and is not stalled, is followed by address 0 when no exception is pending.
- R7: A step that asserts wait keeps `upc_o` unchanged at every edge where `mem_done` is low. It proceeds at the first edge where `mem_done` is high.
- R8: An `exc_req` pulse is remembered until the next unstalled end step; a pulse in the end step's own cycle also counts. That end step is followed by address 20 instead of 0, and the request is then cleared. Address 20 asserts pc_out and ma_in. Address 21 asserts end.
- R9: `ctl_o` bit positions are fixed. Bits 0 to 3 are pc_out, c_out, md_out and reg_out. Bits 4 to 6 are alu_add, alu_sub and alu_and. Bits 7 and 8 are mem_rd and mem_wr. Bits 9 to 20 are ma_in, inc4, c_in, pc_in, ir_in, a_in, r_in, gra, grb, grc, wait and end. Within each of the three groups (bus, ALU, memory) at most one bit is ever set.
- R10: Add routine 4,5,6. Address 4 asserts reg_out, grb and a_in. Address 5 asserts reg_out, grc, alu_add and c_in. Address 6 asserts c_out, gra, r_in and end. Subtract routine 7,8,9 is the same with alu_sub at 8. Store routine 10,11,12: address 10 asserts reg_out, grb and ma_in; address 11 asserts reg_out, gra, mem_wr and wait; address 12 asserts end. Address 14 asserts end. Address 15 asserts reg_out, grc, pc_in and end. Address 16 jumps unconditionally to 15. Address 18 asserts end. Address 19 asserts reg_out, grb, alu_and, c_in and end. Addresses 3, 13, 16 and 17 assert no control line other than end at 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Macro-opcode used by the dispatch step |
| cond_in | input | CC_W | Condition and status bits tested by conditional micro-branches |
| mem_done | input | 1 | Memory completion, releases a wait step |
| exc_req | input | 1 | Exception request pulse |
| upc_o | output | UPC_W | Current micro-address |
| ctl_o | output | 21 | Decoded control lines, positions as in R9 |

## Verification
A corrupted micro-PC or branch decision shows on `ctl_o` in the same cycle, because the control lines are a pure function of the current address. It shows on `upc_o` one edge after the wrong selection. Every cycle of each routine is compared against the expected address and the full control word, so a wrong map entry or condition tap is seen within two cycles of the dispatch. A lost or stuck exception flag shows only at the following end step, so the bench follows an exception run with an ordinary instruction to catch a flag that was never cleared. A broken wait stall shows as an early advance out of address 1.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {
      BC_NEXT = 2'd0,
      BC_JUMP = 2'd1,
      BC_COND = 2'd2,
      BC_MAP  = 2'd3
   } bc_e;

   // mutually exclusive groups, stored encoded (0 = none)
   localparam int N_BUS  = 4;
   localparam int N_ALU  = 3;
   localparam int N_MEM  = 2;
   localparam int BUS_CW = $clog2(N_BUS + 1);
   localparam int ALU_CW = $clog2(N_ALU + 1);
   localparam int MEM_CW = $clog2(N_MEM + 1);

   localparam logic [BUS_CW-1:0] BUS_NONE = BUS_CW'(0);
   localparam logic [BUS_CW-1:0] BUS_PC   = BUS_CW'(1);
   localparam logic [BUS_CW-1:0] BUS_C    = BUS_CW'(2);
   localparam logic [BUS_CW-1:0] BUS_MD   = BUS_CW'(3);
   localparam logic [BUS_CW-1:0] BUS_REG  = BUS_CW'(4);

   localparam logic [ALU_CW-1:0] ALU_NONE = ALU_CW'(0);
   localparam logic [ALU_CW-1:0] ALU_ADD  = ALU_CW'(1);
   localparam logic [ALU_CW-1:0] ALU_SUB  = ALU_CW'(2);
   localparam logic [ALU_CW-1:0] ALU_AND  = ALU_CW'(3);

   localparam logic [MEM_CW-1:0] MEM_NONE = MEM_CW'(0);
   localparam logic [MEM_CW-1:0] MEM_RD   = MEM_CW'(1);
   localparam logic [MEM_CW-1:0] MEM_WR   = MEM_CW'(2);

   // horizontal (one bit per line) field
   localparam int H_MA_IN = 0;
   localparam int H_INC4  = 1;
   localparam int H_C_IN  = 2;
   localparam int H_PC_IN = 3;
   localparam int H_IR_IN = 4;
   localparam int H_A_IN  = 5;
   localparam int H_R_IN  = 6;
   localparam int H_GRA   = 7;
   localparam int H_GRB   = 8;
   localparam int H_GRC   = 9;
   localparam int H_WAIT  = 10;
   localparam int H_END   = 11;
   localparam int N_HORZ  = 12;

   // output vector layout
   localparam int CTL_BUS_LSB  = 0;
   localparam int CTL_ALU_LSB  = CTL_BUS_LSB + N_BUS;
   localparam int CTL_MEM_LSB  = CTL_ALU_LSB + N_ALU;
   localparam int CTL_HORZ_LSB = CTL_MEM_LSB + N_MEM;
   localparam int N_CTL        = CTL_HORZ_LSB + N_HORZ;
   localparam int CTL_WAIT     = CTL_HORZ_LSB + H_WAIT;
   localparam int CTL_END      = CTL_HORZ_LSB + H_END;

   // control store layout
   localparam int A_FETCH   = 0;
   localparam int A_DISP    = 2;
   localparam int A_NOP     = 3;
   localparam int A_ADD     = 4;
   localparam int A_SUB     = 7;
   localparam int A_ST      = 10;
   localparam int A_BZ      = 13;
   localparam int A_BZ_NT   = 14;
   localparam int A_PCLOAD  = 15;
   localparam int A_JMP     = 16;
   localparam int A_TST     = 17;
   localparam int A_TST_NT  = 18;
   localparam int A_TST_T   = 19;
   localparam int A_EXC     = 20;
   localparam int A_LAST    = 21;

endpackage

// File: rtl/useq_onehot_dec.sv
module useq_onehot_dec #(
   parameter int M  = 4,
   localparam int CW = $clog2(M + 1)
) (
   input  logic [CW-1:0] code,
   output logic [M-1:0]  lines
);
   for (genvar i = 0; i < M; i++) begin : g_line
      assign lines[i] = (code == CW'(i + 1));
   end
endmodule

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int UPC_W  = 5,
   parameter int OPC_W  = 4,
   parameter int CSEL_W = 2
) (
   input  logic [UPC_W-1:0]  upc,
   input  logic [OPC_W-1:0]  opcode,
   output logic [BUS_CW-1:0] bus_code,
   output logic [ALU_CW-1:0] alu_code,
   output logic [MEM_CW-1:0] mem_code,
   output logic [N_HORZ-1:0] horz,
   output bc_e               bc,
   output logic [CSEL_W-1:0] csel,
   output logic [UPC_W-1:0]  baddr,
   output logic [UPC_W-1:0]  map_addr
);
   always_comb begin
      bus_code = BUS_NONE;
      alu_code = ALU_NONE;
      mem_code = MEM_NONE;
      horz     = '0;
      bc       = BC_NEXT;
      csel     = '0;
      baddr    = '0;
      case (int'(upc))
         0: begin
            bus_code = BUS_PC;  mem_code = MEM_RD;
            horz[H_MA_IN] = 1'b1; horz[H_INC4] = 1'b1; horz[H_C_IN] = 1'b1;
         end
         1: begin
            bus_code = BUS_C;
            horz[H_PC_IN] = 1'b1; horz[H_WAIT] = 1'b1;
         end
         A_DISP: begin
            bus_code = BUS_MD; horz[H_IR_IN] = 1'b1; bc = BC_MAP;
         end
         A_NOP, A_ST + 2, A_BZ_NT, A_TST_NT, A_LAST: horz[H_END] = 1'b1;
         A_ADD, A_SUB: begin
            bus_code = BUS_REG; horz[H_GRB] = 1'b1; horz[H_A_IN] = 1'b1;
         end
         A_ADD + 1, A_SUB + 1: begin
            bus_code = BUS_REG; horz[H_GRC] = 1'b1; horz[H_C_IN] = 1'b1;
            alu_code = (int'(upc) == A_ADD + 1) ? ALU_ADD : ALU_SUB;
         end
         A_ADD + 2, A_SUB + 2: begin
            bus_code = BUS_C;
            horz[H_GRA] = 1'b1; horz[H_R_IN] = 1'b1; horz[H_END] = 1'b1;
         end
         A_ST: begin
            bus_code = BUS_REG; horz[H_GRB] = 1'b1; horz[H_MA_IN] = 1'b1;
         end
         A_ST + 1: begin
            bus_code = BUS_REG; mem_code = MEM_WR;
            horz[H_GRA] = 1'b1; horz[H_WAIT] = 1'b1;
         end
         A_BZ: begin
            bc = BC_COND; csel = CSEL_W'(0); baddr = UPC_W'(A_PCLOAD);
         end
         A_PCLOAD: begin
            bus_code = BUS_REG;
            horz[H_GRC] = 1'b1; horz[H_PC_IN] = 1'b1; horz[H_END] = 1'b1;
         end
         A_JMP: begin
            bc = BC_JUMP; baddr = UPC_W'(A_PCLOAD);
         end
         A_TST: begin
            bc = BC_COND; csel = CSEL_W'(3); baddr = UPC_W'(A_TST_T);
         end
         A_TST_T: begin
            bus_code = BUS_REG; alu_code = ALU_AND;
            horz[H_GRB] = 1'b1; horz[H_C_IN] = 1'b1; horz[H_END] = 1'b1;
         end
         A_EXC: begin
            bus_code = BUS_PC; horz[H_MA_IN] = 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      case (int'(opcode))
         0:       map_addr = UPC_W'(A_NOP);
         1:       map_addr = UPC_W'(A_ADD);
         2:       map_addr = UPC_W'(A_SUB);
         3:       map_addr = UPC_W'(A_ST);
         4:       map_addr = UPC_W'(A_BZ);
         5:       map_addr = UPC_W'(A_JMP);
         7:       map_addr = UPC_W'(A_TST);
         default: map_addr = UPC_W'(A_NOP);
      endcase
   end
endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int UPC_W   = 5,
   parameter int CC_W    = 4,
   parameter int CSEL_W  = 2,
   parameter int EXC_VEC = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  bc_e               bc,
   input  logic [CSEL_W-1:0] csel,
   input  logic [UPC_W-1:0]  baddr,
   input  logic [UPC_W-1:0]  map_addr,
   input  logic [CC_W-1:0]   cond_in,
   input  logic              wait_bit,
   input  logic              end_bit,
   input  logic              mem_done,
   input  logic              exc_req,
   output logic [UPC_W-1:0]  upc
);
   logic [UPC_W-1:0] upc_inc, upc_nxt;
   logic             hold, pend_q, pend_any, cond_hit;

   assign upc_inc  = upc + 1'b1;
   assign hold     = wait_bit & ~mem_done;
   assign pend_any = pend_q | exc_req;
   assign cond_hit = cond_in[csel];

   always_comb begin
      if (hold)         upc_nxt = upc;
      else if (end_bit) upc_nxt = pend_any ? UPC_W'(EXC_VEC) : '0;
      else begin
         case (bc)
            BC_NEXT: upc_nxt = upc_inc;
            BC_JUMP: upc_nxt = baddr;
            BC_COND: upc_nxt = cond_hit ? baddr : upc_inc;
            default: upc_nxt = map_addr;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         upc    <= '0;
         pend_q <= 1'b0;
      end else begin
         upc    <= upc_nxt;
         pend_q <= (end_bit & ~hold) ? 1'b0 : pend_any;
      end
   end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
   import useq_pkg::*;
#(
   parameter int UPC_W = 5,
   parameter int OPC_W = 4,
   parameter int CC_W  = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [OPC_W-1:0]   opcode,
   input  logic [CC_W-1:0]    cond_in,
   input  logic               mem_done,
   input  logic               exc_req,
   output logic [UPC_W-1:0]   upc_o,
   output logic [N_CTL-1:0]   ctl_o
);
   localparam int CSEL_W = (CC_W > 1) ? $clog2(CC_W) : 1;

   if (UPC_W < 5 || OPC_W < 3 || CC_W < 4) begin : g_bad_params
      initial $fatal(1, "useq_ctrl: store needs UPC_W>=5, OPC_W>=3, CC_W>=4");
   end

   logic [UPC_W-1:0]  upc;
   logic [BUS_CW-1:0] st_bus;
   logic [ALU_CW-1:0] st_alu;
   logic [MEM_CW-1:0] st_mem;
   logic [N_HORZ-1:0] st_horz;
   bc_e               st_bc;
   logic [CSEL_W-1:0] st_csel;
   logic [UPC_W-1:0]  st_baddr, st_map;

   useq_store #(.UPC_W(UPC_W), .OPC_W(OPC_W), .CSEL_W(CSEL_W)) u_store (
      .upc(upc), .opcode(opcode),
      .bus_code(st_bus), .alu_code(st_alu), .mem_code(st_mem), .horz(st_horz),
      .bc(st_bc), .csel(st_csel), .baddr(st_baddr), .map_addr(st_map)
   );

   useq_next #(.UPC_W(UPC_W), .CC_W(CC_W), .CSEL_W(CSEL_W), .EXC_VEC(A_EXC)) u_next (
      .clk(clk), .rst(rst), .bc(st_bc), .csel(st_csel), .baddr(st_baddr),
      .map_addr(st_map), .cond_in(cond_in),
      .wait_bit(st_horz[H_WAIT]), .end_bit(st_horz[H_END]),
      .mem_done(mem_done), .exc_req(exc_req), .upc(upc)
   );

   useq_onehot_dec #(.M(N_BUS)) u_bus_dec (
      .code(st_bus), .lines(ctl_o[CTL_BUS_LSB +: N_BUS]));
   useq_onehot_dec #(.M(N_ALU)) u_alu_dec (
      .code(st_alu), .lines(ctl_o[CTL_ALU_LSB +: N_ALU]));
   useq_onehot_dec #(.M(N_MEM)) u_mem_dec (
      .code(st_mem), .lines(ctl_o[CTL_MEM_LSB +: N_MEM]));

   assign ctl_o[CTL_HORZ_LSB +: N_HORZ] = st_horz;
   assign upc_o = upc;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
   import useq_pkg::*;
#(
   parameter int UPC_W = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             mem_done,
   input logic             exc_req,
   input logic [UPC_W-1:0] upc_o,
   input logic [N_CTL-1:0] ctl_o,
   input bc_e              bc,
   input logic [UPC_W-1:0] baddr
);
   localparam logic [UPC_W-1:0] VEC = UPC_W'(A_EXC);

   logic stalled;
   assign stalled = ctl_o[CTL_WAIT] & ~mem_done;

   // R1
   reset_home_chk: assert property (@(posedge clk) rst |=> (upc_o == '0));

   // R7
   wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
      stalled |=> $stable(upc_o));

   // R6
   end_return_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_o[CTL_END] && !stalled) |=> (upc_o == '0 || upc_o == VEC));

   // R8
   exc_take_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_o[CTL_END] && !stalled && exc_req) |=> (upc_o == VEC));

   // R3
   jump_target_chk: assert property (@(posedge clk) disable iff (rst)
      (bc == BC_JUMP && !stalled && !ctl_o[CTL_END]) |=> (upc_o == $past(baddr)));

   // R3
   step_inc_chk: assert property (@(posedge clk) disable iff (rst)
      (bc == BC_NEXT && !stalled && !ctl_o[CTL_END])
      |=> (upc_o == UPC_W'($past(upc_o) + 1'b1)));

   // R9
   bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ctl_o[CTL_BUS_LSB +: N_BUS]));

   // R9
   alu_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ctl_o[CTL_ALU_LSB +: N_ALU]));

   // R9
   mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ctl_o[CTL_MEM_LSB +: N_MEM]));
endmodule

bind useq_ctrl useq_ctrl_chk #(.UPC_W(UPC_W)) u_chk (
   .clk(clk), .rst(rst), .mem_done(mem_done), .exc_req(exc_req),
   .upc_o(upc_o), .ctl_o(ctl_o), .bc(st_bc), .baddr(st_baddr)
);

// File: tb/useq_ctrl_tb.sv
`timescale 1ns/1ps
module useq_ctrl_tb;
   localparam int UPC_W = 5;
   localparam int OPC_W = 4;
   localparam int CC_W  = 4;
   localparam int NC    = 21;

   // ctl_o bit positions (R9)
   localparam int PCO = 0, CO = 1, MDO = 2, RO = 3, ADD = 4, SUB = 5, ANDF = 6;
   localparam int RD = 7, WR = 8, MAI = 9, INC = 10, CI = 11, PCI = 12, IRI = 13;
   localparam int AI = 14, RI = 15, GA = 16, GB = 17, GC = 18, WT = 19, EN = 20;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [OPC_W-1:0] opcode = '0;
   logic [CC_W-1:0]  cond_in = '0;
   logic             mem_done = 1'b1;
   logic             exc_req = 1'b0;
   logic [UPC_W-1:0] upc_o;
   logic [NC-1:0]    ctl_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   useq_ctrl #(.UPC_W(UPC_W), .OPC_W(OPC_W), .CC_W(CC_W)) u_dut (
      .clk(clk), .rst(rst), .opcode(opcode), .cond_in(cond_in),
      .mem_done(mem_done), .exc_req(exc_req), .upc_o(upc_o), .ctl_o(ctl_o));

   // expected control word per address (R2, R8, R10)
   function automatic logic [NC-1:0] exp_ctl(input int a);
      logic [NC-1:0] v;
      v = '0;
      case (a)
         0:  begin v[PCO]=1; v[RD]=1; v[MAI]=1; v[INC]=1; v[CI]=1; end
         1:  begin v[CO]=1; v[PCI]=1; v[WT]=1; end
         2:  begin v[MDO]=1; v[IRI]=1; end
         3, 12, 14, 18, 21: v[EN]=1;
         4, 7: begin v[RO]=1; v[GB]=1; v[AI]=1; end
         5:  begin v[RO]=1; v[GC]=1; v[ADD]=1; v[CI]=1; end
         8:  begin v[RO]=1; v[GC]=1; v[SUB]=1; v[CI]=1; end
         6, 9: begin v[CO]=1; v[GA]=1; v[RI]=1; v[EN]=1; end
         10: begin v[RO]=1; v[GB]=1; v[MAI]=1; end
         11: begin v[RO]=1; v[GA]=1; v[WR]=1; v[WT]=1; end
         15: begin v[RO]=1; v[GC]=1; v[PCI]=1; v[EN]=1; end
         19: begin v[RO]=1; v[GB]=1; v[ANDF]=1; v[CI]=1; v[EN]=1; end
         20: begin v[PCO]=1; v[MAI]=1; end
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic check_state(input string req, input int a);
      n_chk++;
      if (int'(upc_o) != a || ctl_o !== exp_ctl(a)) begin
         n_fail++;
         $display("FAIL %s: upc=%0d ctl=%h expected upc=%0d ctl=%h",
                  req, upc_o, ctl_o, a, exp_ctl(a));
      end
   endtask

   task automatic step(input string req, input int a);
      check_state(req, a);
      @(negedge clk);
   endtask

   // vector: {opcode[3:0], cond[3:0], len[2:0], route 4 x 5 bits}
   localparam int NV = 12;
   localparam logic [30:0] VEC [NV] = '{
      {4'd0, 4'h0, 3'd1, 5'd3,  5'd0,  5'd0, 5'd0},
      {4'd1, 4'h0, 3'd3, 5'd4,  5'd5,  5'd6, 5'd0},
      {4'd2, 4'h0, 3'd3, 5'd7,  5'd8,  5'd9, 5'd0},
      {4'd3, 4'h0, 3'd3, 5'd10, 5'd11, 5'd12, 5'd0},
      {4'd4, 4'h1, 3'd2, 5'd13, 5'd15, 5'd0, 5'd0},
      {4'd4, 4'h0, 3'd2, 5'd13, 5'd14, 5'd0, 5'd0},
      {4'd4, 4'hE, 3'd2, 5'd13, 5'd14, 5'd0, 5'd0},
      {4'd5, 4'h0, 3'd2, 5'd16, 5'd15, 5'd0, 5'd0},
      {4'd6, 4'h0, 3'd1, 5'd3,  5'd0,  5'd0, 5'd0},
      {4'd7, 4'h8, 3'd2, 5'd17, 5'd19, 5'd0, 5'd0},
      {4'd7, 4'h7, 3'd2, 5'd17, 5'd18, 5'd0, 5'd0},
      {4'd9, 4'hF, 3'd1, 5'd3,  5'd0,  5'd0, 5'd0}
   };

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state, fetch step 0 controls
      check_state("R1", 0);

      // table walk: fetch R2, map R4, branches R3 R5, routines R10, return R6
      for (int i = 0; i < NV; i++) begin
         opcode  = VEC[i][30:27];
         cond_in = VEC[i][26:23];
         step("R6", 0);
         step("R2", 1);
         step("R2", 2);
         for (int k = 0; k < int'(VEC[i][22:20]); k++)
            step("R3/R4/R5/R10", int'(VEC[i][19-5*k -: 5]));
      end

      // R7: wait stall then release
      opcode = 4'd0; cond_in = '0;
      mem_done = 1'b0;
      step("R7", 0);
      step("R7", 1);
      step("R7", 1);
      mem_done = 1'b1;
      step("R7", 1);
      step("R7", 2);
      step("R7", 3);

      // R8: request early, taken at the add routine's end step
      exc_req = 1'b1; opcode = 4'd1;
      step("R8", 0);
      exc_req = 1'b0;
      step("R8", 1);
      step("R8", 2);
      step("R8", 4);
      step("R8", 5);
      step("R8", 6);
      step("R8", 20);
      step("R8", 21);
      // R8: request cleared after being taken
      opcode = 4'd0;
      step("R8", 0);
      step("R8", 1);
      step("R8", 2);
      step("R8", 3);
      // R8: request in the end step's own cycle
      step("R8", 0);
      step("R8", 1);
      step("R8", 2);
      exc_req = 1'b1;
      step("R8", 3);
      exc_req = 1'b0;
      step("R8", 20);
      step("R8", 21);

      // R1: reset overrides a wait stall and discards a pending request
      exc_req = 1'b1;
      step("R1", 0);
      exc_req = 1'b0; mem_done = 1'b0;
      step("R7", 1);
      rst = 1'b1;
      step("R7", 1);
      rst = 1'b0; mem_done = 1'b1;
      step("R1", 0);
      step("R1", 1);
      step("R1", 2);
      step("R1", 3);
      step("R1", 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule